// File: doc/BRIEF.md
# Receive FIFO with Flush Control

This block is the receive-side byte store of one serial channel. The receiver pushes bytes in through a write port and the host pops them through a read port. A read-only count reports how many bytes are held. The oldest byte comes out first. Read data is registered, so a byte appears on `rd_data` in the cycle after the read request.

A small write-only control register decides when the store is emptied. A software reset bit flushes it at once and then clears itself. Two auto-flush bits make the store empty itself when the channel's receive-enable input is switched on or switched off. Because the register cannot be read back, the two auto bits are kept in internal state. They hold their value until the next control write. A flush clears both pointers and the count in a single clock. It also discards any push or pop requested in that same cycle.

Top module: `rxq_flush_fifo`

## Requirements
- R1: After reset, `fill_count` is 0, `rd_data` is 0 and `ovf_pulse` is 0. The auto bits are in their reset state: flush-on-enable is set and flush-on-disable is clear. As a result, a later 0-to-1 transition of `rx_enable` flushes the store, and a 1-to-0 transition does not.
- R2: Bytes pushed with `wr_valid` are returned in arrival order. A pop with `rd_en` on a non-empty store places the oldest byte on `rd_data` one clock later. `rd_data` holds its value in cycles without `rd_en`.
- R3: `fill_count[9:0]` gives the number of bytes held, from 0 to 512 (the depth). Bits 15:10 always read 0. A push alone adds one, a pop alone removes one, and a push together with a pop leaves the count unchanged.
- R4: A push while the store is full is dropped, even if a pop happens in the same cycle. A dropped push raises `ovf_pulse` for exactly one clock, in the cycle after the push.
- R5: A pop while the store is empty places 0 on `rd_data` and leaves the count at 0.
- R6: A control write with bit 0 = 1 empties the store in the cycle of the write. The bit clears itself, so no further flush follows. A write with bit 0 = 0 does not flush.
- R7: While flush-on-enable (control bit 1) is set, a 0-to-1 transition of `rx_enable` empties the store. While it is clear, the transition does not.
- R8: While flush-on-disable (control bit 2) is set, a 1-to-0 transition of `rx_enable` empties the store. While it is clear, the transition does not.
- R9: Every control write loads both auto bits from data bits 1 and 2. The auto bits keep their value between writes.
- R10: A flush discards any push or pop requested in the same cycle. Afterwards the count is 0, a discarded pop places 0 on `rd_data`, and `ovf_pulse` stays 0.
- R11: An edge is detected by comparing `rx_enable` with its value at the previous clock, so the flush happens in the first cycle the new level is seen. A control write in that same cycle does not change how that edge is treated: the auto bits in force before the write decide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Receiver push request |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Host pop request |
| rd_data | output | 8 | Popped byte, valid the cycle after `rd_en` |
| ovf_pulse | output | 1 | One-cycle pulse after a dropped push |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data: bit 0 reset, bit 1 flush-on-enable, bit 2 flush-on-disable |
| rx_enable | input | 1 | Channel receive-enable level |
| fill_count | output | 16 | Number of bytes held, in bits 9:0 |

## Verification
The bench builds the block at its default parameters: 8-bit data and a depth of 512. At that depth the ten-bit count reaches its top value of 512, and the full-store cases can be reached: a dropped push, and a push combined with a pop at the full boundary. Both complete within a few thousand cycles. A behavioural queue model follows every clock, including the cases where a flush collides with pushes, pops and control writes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int CTL_RST_BIT = 0;
  localparam int CTL_ON_BIT  = 1;
  localparam int CTL_OFF_BIT = 2;

  typedef struct packed {
    logic on_disable;
    logic on_enable;
  } auto_cfg_t;

  typedef enum logic [1:0] {
    FL_NONE = 2'd0,
    FL_SW   = 2'd1,
    FL_RISE = 2'd2,
    FL_FALL = 2'd3
  } flush_src_t;

  function automatic flush_src_t pick_src(logic sw, logic rise, logic fall,
                                          auto_cfg_t cfg);
    if (sw)                        return FL_SW;
    else if (rise && cfg.on_enable) return FL_RISE;
    else if (fall && cfg.on_disable) return FL_FALL;
    else                           return FL_NONE;
  endfunction
endpackage

// File: rtl/rxq_flush_ctrl.sv
module rxq_flush_ctrl
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [2:0] ctl_bits,
  input  logic       rx_enable,
  output logic       flush_o,
  output flush_src_t src_o
);
  auto_cfg_t auto_q;
  logic      rx_en_q;
  logic      sw_rst, en_rise, en_fall;

  assign sw_rst  = ctl_we && ctl_bits[CTL_RST_BIT];
  assign en_rise = rx_enable && !rx_en_q;
  assign en_fall = !rx_enable && rx_en_q;
  assign src_o   = pick_src(sw_rst, en_rise, en_fall, auto_q);
  assign flush_o = (src_o != FL_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q           <= 1'b0;
      auto_q.on_enable  <= 1'b1;
      auto_q.on_disable <= 1'b0;
    end else begin
      rx_en_q <= rx_enable;
      if (ctl_we) begin
        auto_q.on_enable  <= ctl_bits[CTL_ON_BIT];
        auto_q.on_disable <= ctl_bits[CTL_OFF_BIT];
      end
    end
  end

  // R6: a reset-bit write always produces a flush
  a_r6_sw_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_bits[CTL_RST_BIT]) |-> flush_o);
  // R8: falling edge without flush-on-disable and without software reset gives no flush
  a_r8_no_fall_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_enable && rx_en_q && !auto_q.on_disable && !sw_rst) |-> !flush_o);
  // R9: auto bits hold between writes
  a_r9_auto_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(auto_q));
endmodule

// File: rtl/rxq_ring.sv
module rxq_ring #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 512,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              ovf,
  output logic [LVL_W-1:0]  level
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              is_full, is_empty;
  logic              wr_acc, wr_drop, rd_acc;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [LVL_W-1:0] lvl_next(logic [LVL_W-1:0] l,
                                                logic w, logic r);
    case ({w, r})
      2'b10:   return l + 1'b1;
      2'b01:   return l - 1'b1;
      default: return l;
    endcase
  endfunction

  assign is_full  = (level == FULL_LVL);
  assign is_empty = (level == '0);
  assign wr_acc   = wr_valid && !flush && !is_full;
  assign wr_drop  = wr_valid && !flush && is_full;
  assign rd_acc   = rd_en && !flush && !is_empty;

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      level   <= '0;
      rd_data <= '0;
      ovf     <= 1'b0;
    end else begin
      ovf <= wr_drop;
      if (rd_en) rd_data <= rd_acc ? mem[rptr] : '0;
      if (flush) begin
        wptr  <= '0;
        rptr  <= '0;
        level <= '0;
      end else begin
        if (wr_acc) wptr <= ptr_inc(wptr);
        if (rd_acc) rptr <= ptr_inc(rptr);
        level <= lvl_next(level, wr_acc, rd_acc);
      end
    end
  end

  // R3: level never exceeds depth
  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL_LVL);
  // R4: a push into a full store without a pop keeps it full and pulses overflow
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (is_full && wr_valid && !rd_en && !flush) |=> (is_full && ovf));
  // R5: popping an empty store yields zero
  a_r5_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (is_empty && rd_en) |=> (rd_data == '0 && !ovf));
  // R10: a flush leaves the store empty
  a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (level == '0 && !ovf));
endmodule

// File: rtl/rxq_flush_fifo.sv
module rxq_flush_fifo
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 512,
  parameter int REG_W  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              ovf_pulse,
  input  logic              ctl_we,
  input  logic [REG_W-1:0]  ctl_wdata,
  input  logic              rx_enable,
  output logic [REG_W-1:0]  fill_count
);
  logic             flush_evt;
  flush_src_t       flush_src;
  logic [LVL_W-1:0] level;
  logic             unused_rsvd;

  assign unused_rsvd = ^ctl_wdata[REG_W-1:3];

  rxq_flush_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_bits  (ctl_wdata[2:0]),
    .rx_enable (rx_enable),
    .flush_o   (flush_evt),
    .src_o     (flush_src)
  );

  rxq_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_evt),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .ovf      (ovf_pulse),
    .level    (level)
  );

  assign fill_count = REG_W'(level);

  // R3: upper count bits are zero
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fill_count[REG_W-1:LVL_W] == '0);
  // R4: overflow is a single-cycle pulse
  a_r4_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse || $past(wr_valid));
  // R10: any flush source leaves a zero count on the port
  a_r10_port_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_src != FL_NONE) |=> fill_count == '0);
endmodule

// File: tb/rxq_flush_fifo_tb.sv
module rxq_flush_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 512;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, rd_en = 0, ctl_we = 0, rx_enable = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [15:0] ctl_wdata = 0, fill_count;
  logic ovf_pulse;

  int checks = 0, errors = 0;
  bit done = 0;

  byte unsigned q[$];
  bit m_on = 1, m_off = 0, m_prev = 0, m_ovf = 0;
  logic [7:0] m_rd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxq_flush_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ovf_pulse(ovf_pulse),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .rx_enable(rx_enable),
    .fill_count(fill_count)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    bit sw, rise, fall, fl, full, empty;
    sw = ctl_we && ctl_wdata[0];
    rise = rx_enable && !m_prev;
    fall = !rx_enable && m_prev;
    fl = sw || (rise && m_on) || (fall && m_off);
    if (ctl_we) begin m_on = ctl_wdata[1]; m_off = ctl_wdata[2]; end
    m_prev = rx_enable;
    m_ovf = 0;
    full = (q.size() == DEPTH);
    empty = (q.size() == 0);
    if (fl) begin
      q.delete();
      if (rd_en) m_rd = 0;
    end else begin
      if (rd_en) m_rd = empty ? 8'd0 : q.pop_front();
      if (wr_valid) begin
        if (full) m_ovf = 1; else q.push_back(wr_data);
      end
    end
    @(posedge clk); #1;
    chk(tag, "count", int'(fill_count), q.size());
    chk(tag, "rd_data", int'(rd_data), int'(m_rd));
    chk(tag, "ovf", int'(ovf_pulse), int'(m_ovf));
    wr_valid = 0; rd_en = 0; ctl_we = 0; ctl_wdata = 0;
  endtask

  task automatic push(byte unsigned b, string tag);
    wr_valid = 1; wr_data = b; step(tag);
  endtask
  task automatic pop(string tag);
    rd_en = 1; step(tag);
  endtask
  task automatic ctl(logic [15:0] v, string tag);
    ctl_we = 1; ctl_wdata = v; step(tag);
  endtask
  task automatic en(logic v, string tag);
    rx_enable = v; step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "count", int'(fill_count), 0);
    chk("R1", "rd_data", int'(rd_data), 0);
    chk("R1", "ovf", int'(ovf_pulse), 0);
    rst_n = 1;
    step("R1");

    // R2 ordering
    for (int i = 0; i < 5; i++) push(byte'(8'h30 + i), "R2");
    chk("R3", "count5", int'(fill_count), 5);
    for (int i = 0; i < 5; i++) begin
      pop("R2");
      chk("R2", "order", int'(rd_data), 8'h30 + i);
    end
    step("R2");
    chk("R2", "hold", int'(rd_data), 8'h34);

    // R1/R7 default flush on enable
    for (int i = 0; i < 3; i++) push(byte'(i + 1), "R7");
    en(1, "R7");
    chk("R7", "rise flush", int'(fill_count), 0);
    // R1/R8 default no flush on disable
    push(8'hA1, "R8"); push(8'hA2, "R8");
    en(0, "R8");
    chk("R8", "fall no flush", int'(fill_count), 2);

    // R9: load on-disable only
    ctl(16'h0004, "R9");
    chk("R9", "no flush bit0=0", int'(fill_count), 2);
    en(1, "R9");
    chk("R9", "rise ignored", int'(fill_count), 2);
    push(8'hB0, "R9");
    en(0, "R8");
    chk("R8", "fall flush", int'(fill_count), 0);

    // R6 software reset
    for (int i = 0; i < 4; i++) push(byte'(8'hC0 + i), "R6");
    ctl(16'h0005, "R6");
    chk("R6", "sw flush", int'(fill_count), 0);
    push(8'hD0, "R6"); push(8'hD1, "R6");
    chk("R6", "self-clear", int'(fill_count), 2);

    // R10 flush with simultaneous push and pop
    pop("R10");
    chk("R10", "pre", int'(rd_data), 8'hD0);
    wr_valid = 1; wr_data = 8'hEE; rd_en = 1; ctl_we = 1; ctl_wdata = 16'h0001;
    step("R10");
    chk("R10", "count", int'(fill_count), 0);
    chk("R10", "rd zero", int'(rd_data), 0);

    // R11 same-cycle control write uses old auto bits
    ctl(16'h0002, "R11");
    push(8'h11, "R11");
    rx_enable = 1; ctl_we = 1; ctl_wdata = 16'h0000; step("R11");
    chk("R11", "old on set", int'(fill_count), 0);
    en(0, "R11");
    push(8'h12, "R11");
    rx_enable = 1; ctl_we = 1; ctl_wdata = 16'h0002; step("R11");
    chk("R11", "old on clear", int'(fill_count), 1);
    push(8'h13, "R11");
    en(1, "R11");
    chk("R11", "steady high", int'(fill_count), 2);

    // R3/R4 fill to depth
    ctl(16'h0001, "R3");
    for (int i = 0; i < DEPTH; i++) push(byte'(i), "R3");
    chk("R3", "full", int'(fill_count), DEPTH);
    chk("R3", "upper zero", int'(fill_count[15:10]), 0);
    push(8'hFF, "R4");
    chk("R4", "ovf", int'(ovf_pulse), 1);
    step("R4");
    chk("R4", "ovf cleared", int'(ovf_pulse), 0);
    wr_valid = 1; wr_data = 8'h77; rd_en = 1; step("R4");
    chk("R4", "drop with pop", int'(fill_count), DEPTH - 1);
    chk("R4", "drop ovf", int'(ovf_pulse), 1);
    chk("R2", "first out", int'(rd_data), 0);

    // R5 drain then empty pop
    for (int i = 1; i < DEPTH; i++) pop("R2");
    chk("R3", "empty", int'(fill_count), 0);
    pop("R5");
    chk("R5", "empty rd", int'(rd_data), 0);
    chk("R5", "empty count", int'(fill_count), 0);
    wr_valid = 1; wr_data = 8'h5A; rd_en = 1; step("R5");
    chk("R5", "push+pop empty", int'(fill_count), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule